// File: doc/BRIEF.md
# Radix-10 Signed-Digit Partial Product Generator

This block forms one decimal partial product for a wide decimal multiplier. It receives an N-digit BCD multiplicand, one BCD digit of the multiplier and the next lower multiplier digit. From the pair of multiplier digits it derives a signed radix-10 digit in the range -5..+5. It then returns the multiplicand times that signed digit. The result is a row of N+1 digits in a redundant excess-3 code, plus a hot-one bit that the downstream adder tree adds at the least significant digit.

All six positive multiples 0X..5X are built at once, and no carry travels more than one digit position. Each output digit depends only on the matching multiplicand digit and the one below it. A negative multiple is the bitwise inverse of the positive one, because the excess-3 code is self-complementing. The same bits are also offered as an overloaded-digit row (each nibble read as a plain value 0..15). That row differs from the true value by a fixed constant, which the reduction tree can absorb.

An N-digit multiplier needs N+1 rows. The top row is obtained by presenting a zero multiplier digit with the top multiplier digit as the lower neighbour. Results are registered and appear one clock after the inputs.

Top module: `dec_ppgen`

## Requirements
- R1: `sd_o` (4-bit two's complement) equals y - 10·(y ≥ 5) + (ylo ≥ 5), where y = `mdig_i` and ylo = `mdig_lo_i`. It always lies in [-5, 5].
- R2: With y = 0, the signed digit equals 1 when ylo ≥ 5 and 0 otherwise. This is the extra top row of the multiplier.
- R3: When `sd_o` > 0, the row `pp_xs3_o` has nibble j at bits [4j+3:4j], for j = 0..N. Nibble j encodes digit value e_j - 3, and the sum of (e_j - 3)·10^j equals `sd_o`·X, where X is the multiplicand's value.
- R4: When `sd_o` < 0, `neg_o` = 1 and every nibble is the bit inverse of the positive multiple |`sd_o`|·X. As a result, the row value plus 1 equals 10^(N+1) - |`sd_o`|·X.
- R5: When `sd_o` = 0, every nibble of `pp_xs3_o` is 4'b0011 (digit value zero) and `neg_o` = 0.
- R6: `pp_ovl_o` holds nibbles in [0, 15]. Its value, the sum of e_j·10^j, minus the constant 3·(10^(N+1) - 1)/9 equals the value of `pp_xs3_o`.
- R7: Outputs change exactly one clock after the inputs. While `rst` is high, they hold `sd_o` = 0, `neg_o` = 0 and the zero row of R5.
- R8: Every nibble code e_j is at most 13 when `neg_o` = 0 and at least 2 when `neg_o` = 1.
- R9: Changing multiplicand digit k leaves every output nibble other than k and k+1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcand_i | input | 4*NDIGITS | BCD multiplicand, digit j at bits [4j+3:4j] |
| mdig_i | input | 4 | Multiplier digit being recoded |
| mdig_lo_i | input | 4 | Next lower multiplier digit (0 for the lowest row) |
| sd_o | output | 4 | Recoded signed digit, two's complement |
| neg_o | output | 1 | Sign of the row and hot-one bit for the adder tree |
| pp_xs3_o | output | 4*(NDIGITS+1) | Partial product, redundant excess-3 digits |
| pp_ovl_o | output | 4*(NDIGITS+1) | Same row read as overloaded 0..15 digits (zero when OVL_EN = 0) |

## Verification
A bad recoding surfaces on the very next clock as a wrong `sd_o` or a wrong sign bit. A bad multiple or select surfaces on the same clock as a row value that no longer matches the signed digit times the multiplicand. Digit-locality faults (a carry reaching two positions) show up as a changed nibble far from the disturbed multiplicand digit. Every result is one register deep, so no fault hides for more than one cycle. Bit inversion faults show up only for negative digits, so all one hundred digit pairs are swept.

// File: rtl/dec_ppgen_pkg.sv
package dec_ppgen_pkg;

  localparam int MAX_MAG  = 5;
  localparam int NUM_MULT = MAX_MAG + 1;
  localparam int MAG_W    = $clog2(NUM_MULT);
  localparam logic [3:0] XS3_ZERO = 4'd3;

  // A digit product k*x (plus the excess-3 bias) split into a transfer
  // to the next position (0..4) and a local biased part (0..9).
  typedef struct packed {
    logic [2:0] hi;
    logic [3:0] lo;
  } split_t;

  function automatic split_t split_product(input logic [2:0] k, input logic [3:0] x);
    logic [5:0] q;
    split_t r;
    q = 6'({3'b000, k}) * 6'({2'b00, x}) + 6'd3;
    if (q >= 6'd40)      r.hi = 3'd4;
    else if (q >= 6'd30) r.hi = 3'd3;
    else if (q >= 6'd20) r.hi = 3'd2;
    else if (q >= 6'd10) r.hi = 3'd1;
    else                 r.hi = 3'd0;
    r.lo = 4'(q - 6'(r.hi) * 6'd10);
    return r;
  endfunction

endpackage

// File: rtl/dec_sd_recode.sv
module dec_sd_recode
  import dec_ppgen_pkg::*;
(
  input  logic [3:0]          dig_i,
  input  logic [3:0]          dig_lo_i,
  output logic signed [3:0]   sd_o,
  output logic                neg_o,
  output logic [NUM_MULT-1:0] sel_o
);

  logic       hi_ge5;
  logic       lo_ge5;
  logic [4:0] t;
  logic [4:0] mag;

  assign hi_ge5 = (dig_i >= 4'd5);
  assign lo_ge5 = (dig_lo_i >= 4'd5);

  // Five-bit modular arithmetic; the result lies in [-5, 5].
  assign t     = {1'b0, dig_i} - (hi_ge5 ? 5'd10 : 5'd0) + {4'd0, lo_ge5};
  assign neg_o = t[4];
  assign sd_o  = $signed(t[3:0]);
  assign mag   = neg_o ? (5'd0 - t) : t;

  for (genvar k = 0; k < NUM_MULT; k++) begin : g_sel
    assign sel_o[k] = (mag == 5'(k));
  end

endmodule

// File: rtl/dec_mult_gen.sv
module dec_mult_gen
  import dec_ppgen_pkg::*;
#(
  parameter  int NDIGITS  = 16,
  localparam int NDIG_OUT = NDIGITS + 1,
  localparam int ROW_W    = 4 * NDIG_OUT
)(
  input  logic [4*NDIGITS-1:0]       mcand_i,
  output logic [NUM_MULT*ROW_W-1:0]  mult_o
);

  // Multiplicand digits extended with a zero above the top.
  logic [3:0] xd [NDIG_OUT];

  for (genvar j = 0; j < NDIG_OUT; j++) begin : g_ext
    if (j < NDIGITS) begin : g_real
      assign xd[j] = mcand_i[4*j +: 4];
    end else begin : g_pad
      assign xd[j] = 4'd0;
    end
  end

  // Each digit of each multiple sees only its own multiplicand digit and
  // the one below it: no carry chain.
  for (genvar k = 0; k < NUM_MULT; k++) begin : g_mult
    for (genvar j = 0; j < NDIG_OUT; j++) begin : g_dig
      split_t cur;
      split_t prv;
      assign cur = split_product(3'(k), xd[j]);
      if (j == 0) begin : g_bottom
        assign prv = '0;
      end else begin : g_upper
        assign prv = split_product(3'(k), xd[j-1]);
      end
      assign mult_o[k*ROW_W + 4*j +: 4] = cur.lo + {1'b0, prv.hi};
    end
  end

endmodule

// File: rtl/dec_pp_select.sv
module dec_pp_select
  import dec_ppgen_pkg::*;
#(
  parameter  int NDIGITS  = 16,
  localparam int NDIG_OUT = NDIGITS + 1,
  localparam int ROW_W    = 4 * NDIG_OUT
)(
  input  logic [NUM_MULT*ROW_W-1:0] mult_i,
  input  logic [NUM_MULT-1:0]       sel_i,
  input  logic                      neg_i,
  output logic [ROW_W-1:0]          pp_o
);

  logic [ROW_W-1:0] acc;

  // AND-OR selection on a one-hot select.
  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_MULT; k++) begin
      if (sel_i[k]) acc = acc | mult_i[k*ROW_W +: ROW_W];
    end
  end

  // The excess-3 code is self-complementing: inversion gives the nines' complement.
  assign pp_o = acc ^ {ROW_W{neg_i}};

endmodule

// File: rtl/dec_ppgen.sv
module dec_ppgen
  import dec_ppgen_pkg::*;
#(
  parameter  int NDIGITS  = 16,
  parameter  bit OVL_EN   = 1'b1,
  localparam int NDIG_OUT = NDIGITS + 1,
  localparam int ROW_W    = 4 * NDIG_OUT
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [4*NDIGITS-1:0]  mcand_i,
  input  logic [3:0]            mdig_i,
  input  logic [3:0]            mdig_lo_i,
  output logic signed [3:0]     sd_o,
  output logic                  neg_o,
  output logic [ROW_W-1:0]      pp_xs3_o,
  output logic [ROW_W-1:0]      pp_ovl_o
);

  localparam logic [ROW_W-1:0] ZERO_ROW = {NDIG_OUT{XS3_ZERO}};

  logic signed [3:0]          sd_w;
  logic                       neg_w;
  logic [NUM_MULT-1:0]        sel_w;
  logic [NUM_MULT*ROW_W-1:0]  mult_w;
  logic [ROW_W-1:0]           pp_w;

  dec_sd_recode u_recode (
    .dig_i    (mdig_i),
    .dig_lo_i (mdig_lo_i),
    .sd_o     (sd_w),
    .neg_o    (neg_w),
    .sel_o    (sel_w)
  );

  dec_mult_gen #(.NDIGITS(NDIGITS)) u_mult (
    .mcand_i (mcand_i),
    .mult_o  (mult_w)
  );

  dec_pp_select #(.NDIGITS(NDIGITS)) u_sel (
    .mult_i (mult_w),
    .sel_i  (sel_w),
    .neg_i  (neg_w),
    .pp_o   (pp_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_o     <= 4'sd0;
      neg_o    <= 1'b0;
      pp_xs3_o <= ZERO_ROW;
    end else begin
      sd_o     <= sd_w;
      neg_o    <= neg_w;
      pp_xs3_o <= pp_w;
    end
  end

  // Overloaded-digit view: same nibbles, read as plain 0..15 values.
  if (OVL_EN) begin : g_ovl
    always_ff @(posedge clk) begin
      if (rst) pp_ovl_o <= ZERO_ROW;
      else     pp_ovl_o <= pp_w;
    end
  end else begin : g_no_ovl
    assign pp_ovl_o = '0;
  end

endmodule

// File: rtl/dec_ppgen_chk.sv
module dec_ppgen_chk
  import dec_ppgen_pkg::*;
#(
  parameter  int NDIGITS  = 16,
  localparam int NDIG_OUT = NDIGITS + 1,
  localparam int ROW_W    = 4 * NDIG_OUT
)(
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          mdig_i,
  input  logic [3:0]          mdig_lo_i,
  input  logic signed [3:0]   sd_o,
  input  logic                neg_o,
  input  logic [ROW_W-1:0]    pp_xs3_o,
  input  logic [NUM_MULT-1:0] sel_w
);

  localparam logic [ROW_W-1:0] ZERO_ROW = {NDIG_OUT{XS3_ZERO}};

  assert_sd_range_R1: assert property (@(posedge clk) disable iff (rst)
    (sd_o >= -4'sd5) && (sd_o <= 4'sd5));

  assert_plain_recode_R1: assert property (@(posedge clk) disable iff (rst)
    (mdig_i < 4'd5 && mdig_lo_i < 4'd5) |=> (sd_o == $signed($past(mdig_i))));

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_w) == 1);

  assert_hot_one_R4: assert property (@(posedge clk) disable iff (rst)
    neg_o == (sd_o < 4'sd0));

  assert_zero_row_R5: assert property (@(posedge clk) disable iff (rst)
    (sd_o == 4'sd0) |-> (pp_xs3_o == ZERO_ROW));

  for (genvar j = 0; j < NDIG_OUT; j++) begin : g_rng
    assert_digit_range_R8: assert property (@(posedge clk) disable iff (rst)
      neg_o ? (pp_xs3_o[4*j +: 4] >= 4'd2) : (pp_xs3_o[4*j +: 4] <= 4'd13));
  end

  // Reset values, checked mid-cycle after an edge that saw reset.
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      assert_reset_R7: assert (sd_o == 4'sd0 && !neg_o && pp_xs3_o == ZERO_ROW);
    end
  end

endmodule

bind dec_ppgen dec_ppgen_chk #(.NDIGITS(NDIGITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mdig_i    (mdig_i),
  .mdig_lo_i (mdig_lo_i),
  .sd_o      (sd_o),
  .neg_o     (neg_o),
  .pp_xs3_o  (pp_xs3_o),
  .sel_w     (sel_w)
);

// File: tb/tb_dec_ppgen.sv
module tb_dec_ppgen;

  localparam int N     = 16;
  localparam int NDO   = N + 1;
  localparam int ROW_W = 4 * NDO;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [4*N-1:0]      mcand = '0;
  logic [3:0]          mdig = 4'd7;
  logic [3:0]          mdig_lo = 4'd8;
  logic signed [3:0]   sd;
  logic                neg;
  logic [ROW_W-1:0]    pp_xs3;
  logic [ROW_W-1:0]    pp_ovl;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dec_ppgen #(.NDIGITS(N), .OVL_EN(1'b1)) dut (
    .clk       (clk),
    .rst       (rst),
    .mcand_i   (mcand),
    .mdig_i    (mdig),
    .mdig_lo_i (mdig_lo),
    .sd_o      (sd),
    .neg_o     (neg),
    .pp_xs3_o  (pp_xs3),
    .pp_ovl_o  (pp_ovl)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint pow10(input int n);
    longint p = 1;
    for (int i = 0; i < n; i++) p *= 10;
    return p;
  endfunction

  function automatic longint bcd_val(input logic [4*N-1:0] x);
    longint acc = 0;
    for (int j = N - 1; j >= 0; j--) acc = acc * 10 + longint'(x[4*j +: 4]);
    return acc;
  endfunction

  function automatic longint xs3_val(input logic [ROW_W-1:0] v);
    longint acc = 0;
    for (int j = NDO - 1; j >= 0; j--) acc = acc * 10 + (longint'(v[4*j +: 4]) - 3);
    return acc;
  endfunction

  function automatic longint ovl_val(input logic [ROW_W-1:0] v);
    longint acc = 0;
    for (int j = NDO - 1; j >= 0; j--) acc = acc * 10 + longint'(v[4*j +: 4]);
    return acc;
  endfunction

  function automatic longint ovl_bias();
    longint acc = 0;
    for (int j = 0; j < NDO; j++) acc = acc * 10 + 3;
    return acc;
  endfunction

  function automatic int exp_sd(input logic [3:0] y, input logic [3:0] ylo);
    return int'(y) - ((y >= 4'd5) ? 10 : 0) + ((ylo >= 4'd5) ? 1 : 0);
  endfunction

  function automatic logic [4*N-1:0] rand_bcd();
    logic [4*N-1:0] x;
    for (int j = 0; j < N; j++) x[4*j +: 4] = 4'($urandom_range(0, 9));
    return x;
  endfunction

  // Drive at a falling edge; the result is visible at the next falling edge.
  task automatic apply(input logic [4*N-1:0] x, input logic [3:0] y, input logic [3:0] ylo);
    mcand   = x;
    mdig    = y;
    mdig_lo = ylo;
    @(negedge clk);
  endtask

  task automatic check_row(input logic [4*N-1:0] x, input logic [3:0] y, input logic [3:0] ylo);
    int     e    = exp_sd(y, ylo);
    longint mag  = longint'(e < 0 ? -e : e);
    longint prod = mag * bcd_val(x);
    longint val  = xs3_val(pp_xs3);
    bit     rng  = 1'b1;
    check(int'(sd) == e, "R1 signed digit", longint'(sd), longint'(e));
    check(neg == (e < 0), "R4 hot-one bit", longint'(neg), longint'(e < 0));
    if (e > 0)      check(val == prod, "R3 positive row value", val, prod);
    else if (e < 0) check(val + 1 == pow10(NDO) - prod, "R4 negative row value", val + 1, pow10(NDO) - prod);
    else            check(val == 0, "R5 zero row value", val, 0);
    check(ovl_val(pp_ovl) - ovl_bias() == val, "R6 overloaded row", ovl_val(pp_ovl) - ovl_bias(), val);
    for (int j = 0; j < NDO; j++) begin
      if (neg ? (pp_xs3[4*j +: 4] < 4'd2) : (pp_xs3[4*j +: 4] > 4'd13)) rng = 1'b0;
    end
    check(rng, "R8 digit code range", longint'(rng), 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(sd == 4'sd0 && !neg, "R7 reset sign/digit", longint'(sd), 0);
    check(pp_xs3 == {NDO{4'd3}}, "R7 reset row", xs3_val(pp_xs3), 0);
    rst = 1'b0;
  endtask

  task automatic t_latency();
    logic [4*N-1:0] x = rand_bcd();
    apply(x, 4'd0, 4'd0);
    mdig = 4'd3;
    #2;
    check(sd == 4'sd0, "R7 no change before edge", longint'(sd), 0);
    @(negedge clk);
    check(sd == 4'sd3, "R7 one-cycle latency", longint'(sd), 3);
  endtask

  task automatic t_all_pairs();
    logic [4*N-1:0] x = rand_bcd();
    for (int y = 0; y < 10; y++) begin
      for (int l = 0; l < 10; l++) begin
        apply(x, 4'(y), 4'(l));
        check_row(x, 4'(y), 4'(l));
      end
    end
  endtask

  task automatic t_top_row();
    logic [4*N-1:0] x = rand_bcd();
    for (int l = 0; l < 10; l++) begin
      apply(x, 4'd0, 4'(l));
      check(int'(sd) == ((l >= 5) ? 1 : 0), "R2 top row digit", longint'(sd), longint'(l >= 5));
    end
  endtask

  task automatic t_zero();
    apply(rand_bcd(), 4'd9, 4'd6);
    check(pp_xs3 == {NDO{4'd3}} && !neg, "R5 zero from 9 with raised lower", xs3_val(pp_xs3), 0);
    apply({N{4'd9}}, 4'd0, 4'd2);
    check(pp_xs3 == {NDO{4'd3}} && !neg, "R5 zero digit", xs3_val(pp_xs3), 0);
  endtask

  task automatic t_extremes();
    apply({N{4'd9}}, 4'd4, 4'd9);
    check_row({N{4'd9}}, 4'd4, 4'd9);
    apply({N{4'd9}}, 4'd5, 4'd0);
    check_row({N{4'd9}}, 4'd5, 4'd0);
    apply('0, 4'd6, 4'd3);
    check_row('0, 4'd6, 4'd3);
  endtask

  task automatic t_locality(input logic [3:0] y, input logic [3:0] ylo);
    for (int k = 0; k < N; k++) begin
      logic [4*N-1:0] x1 = rand_bcd();
      logic [4*N-1:0] x2 = x1;
      logic [ROW_W-1:0] r1;
      bit same = 1'b1;
      x2[4*k +: 4] = 4'((int'(x1[4*k +: 4]) + 1 + $urandom_range(0, 8)) % 10);
      apply(x1, y, ylo);
      r1 = pp_xs3;
      apply(x2, y, ylo);
      for (int j = 0; j < NDO; j++) begin
        if (j != k && j != k + 1 && pp_xs3[4*j +: 4] != r1[4*j +: 4]) same = 1'b0;
      end
      check(same, "R9 change stays local", longint'(same), 1);
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 2000; i++) begin
      logic [4*N-1:0] x = rand_bcd();
      logic [3:0] y   = 4'($urandom_range(0, 9));
      logic [3:0] ylo = 4'($urandom_range(0, 9));
      apply(x, y, ylo);
      check_row(x, y, ylo);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_all_pairs();
    t_top_row();
    t_zero();
    t_extremes();
    t_locality(4'd4, 4'd7);
    t_locality(4'd7, 4'd0);
    t_random();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule